// File: doc/BRIEF.md
# Orientation State Debouncer

This block decides which of six orientations a device rests in, from signed three-axis acceleration samples that arrive on a strobe at the orientation update rate. For each sample it picks the axis with the largest magnitude. If that magnitude is above a programmable threshold, the sign of that axis selects one face or edge state. A sample below the threshold leaves the candidate at the current state.

A candidate replaces the current state only after it has held for a programmed number of consecutive samples. When that happens, the state being replaced moves into a previous-state register. A change flag latches when the entered state is enabled in a per-state mask, and it stays set until a release strobe. Configuration registers can be written only while the global operate input is low. Samples are used only while the block is both operating and enabled.

Top module: `orient_debounce`

## Requirements
- R1: State values are one-hot in bits 5..0, with the meaning X- (5), X+ (4), Y- (3), Y+ (2), Z- (1), Z+ (0). Bits 7..6 of both state outputs read zero. The current and previous outputs both reset to 0x20, and the change flag resets to 0.
- R2: A sample's candidate is the axis with the largest absolute value, ties going X before Y before Z, with a negative sign selecting the minus state. It counts only if the magnitude is strictly greater than threshold×16 counts. Otherwise the candidate equals the current state. Full scale -2048 classifies as the minus state of its axis.
- R3: With persistence value T, a candidate differing from the current state is accepted on the (T+1)th consecutive processed sample that shows it. T=0 accepts on the first such sample. The outputs change at the clock edge where that sample is strobed.
- R4: A processed sample with a different candidate restarts the count for the new candidate. A sample whose candidate equals the current state clears any pending count.
- R5: On acceptance, the previous-state output takes the value the current-state output held just before.
- R6: The change flag sets on acceptance only if the entered state's bit is 1 in the 6-bit mask, laid out as in R1, which resets to 0x3F. Entering a masked state updates the state outputs without setting the flag.
- R7: The change flag stays set until a cycle with int_rel high. If a flag-setting acceptance and a release occur in the same cycle, the flag ends set.
- R8: A strobed sample is ignored unless run=1 and the enable bit is 1. The enable bit resets to 0.
- R9: Configuration writes take effect only while run=0, and are ignored while run=1. The address map is: 0 = persistence count (resets 0); 1 = mask in bits 5..0; 2 = threshold (resets 0x20); 3 = enable in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Global operate bit; locks configuration when 1 |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| smp_vld | input | 1 | New acceleration sample strobe |
| acc_x | input | DATA_W | X sample, two's complement |
| acc_y | input | DATA_W | Y sample, two's complement |
| acc_z | input | DATA_W | Z sample, two's complement |
| int_rel | input | 1 | Release strobe for the change flag |
| pos_cur | output | 8 | Current orientation |
| pos_prev | output | 8 | Previous orientation |
| pos_chg | output | 1 | Latched orientation change flag |

## Verification
If the pending-candidate tracker or its counter is wrong, the fault shows as a state output that changes one or more strobes too early or too late. A single short burst of a new orientation exposes this within a few samples. A corrupted current register shows as a non-one-hot pos_cur, or as a pos_prev that does not match the old pos_cur on the next acceptance. A mask or flag fault shows as pos_chg disagreeing with the mask in the same cycle as the acceptance.

// File: rtl/orient_pkg.sv
package orient_pkg;
  localparam int POS_W  = 6;
  localparam int AXES   = 3;
  localparam int CNT_W  = 8;
  localparam int CFG_DW = 8;

  localparam logic [POS_W-1:0] POS_RESET   = 6'b100000;
  localparam logic [POS_W-1:0] MASK_RESET  = 6'b111111;
  localparam logic [CFG_DW-1:0] THR_RESET  = 8'h20;

  typedef enum logic [1:0] {
    CFG_PERSIST = 2'd0,
    CFG_MASK    = 2'd1,
    CFG_THRESH  = 2'd2,
    CFG_CTRL    = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/orient_classify.sv
module orient_classify
  import orient_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic signed [DATA_W-1:0] ax,
  input  logic signed [DATA_W-1:0] ay,
  input  logic signed [DATA_W-1:0] az,
  input  logic [CFG_DW-1:0]        thr,
  input  logic [POS_W-1:0]         cur,
  output logic [POS_W-1:0]         cand
);
  localparam int SHIFT = DATA_W - CFG_DW;

  logic signed [DATA_W-1:0] axis_v [AXES];
  logic [DATA_W-1:0]        mag    [AXES];
  logic                     neg    [AXES];

  assign axis_v[0] = ax;
  assign axis_v[1] = ay;
  assign axis_v[2] = az;

  // magnitude per axis; -full scale maps to 2^(DATA_W-1) unsigned
  generate
    for (genvar g = 0; g < AXES; g++) begin : g_abs
      assign neg[g] = axis_v[g][DATA_W-1];
      assign mag[g] = neg[g] ? DATA_W'(-axis_v[g]) : DATA_W'(axis_v[g]);
    end
  endgenerate

  logic [1:0]        sel;
  logic [DATA_W-1:0] mag_max;
  logic [DATA_W-1:0] thr_lim;
  int                bit_idx;

  always_comb begin
    if (mag[0] >= mag[1] && mag[0] >= mag[2]) begin
      sel = 2'd0;
    end else if (mag[1] >= mag[2]) begin
      sel = 2'd1;
    end else begin
      sel = 2'd2;
    end
    mag_max = mag[sel];
    thr_lim = DATA_W'(thr) << SHIFT;
    bit_idx = 2 * (AXES - 1 - int'(sel)) + (neg[sel] ? 1 : 0);
    cand    = cur;
    if (mag_max > thr_lim) begin
      cand          = '0;
      cand[bit_idx] = 1'b1;
    end
  end
endmodule

// File: rtl/orient_cfg.sv
module orient_cfg
  import orient_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CNT_W-1:0]  persist,
  output logic [POS_W-1:0]  mask,
  output logic [CFG_DW-1:0] thr,
  output logic              fn_en
);
  logic [CNT_W-1:0]  persist_q, persist_d;
  logic [POS_W-1:0]  mask_q, mask_d;
  logic [CFG_DW-1:0] thr_q, thr_d;
  logic              en_q, en_d;
  logic              wr_ok;

  assign wr_ok = wr & ~run;

  always_comb begin
    persist_d = persist_q;
    mask_d    = mask_q;
    thr_d     = thr_q;
    en_d      = en_q;
    if (wr_ok) begin
      unique case (cfg_addr_e'(addr))
        CFG_PERSIST: persist_d = wdata[CNT_W-1:0];
        CFG_MASK:    mask_d    = wdata[POS_W-1:0];
        CFG_THRESH:  thr_d     = wdata;
        CFG_CTRL:    en_d      = wdata[0];
        default:     en_d      = en_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      persist_q <= '0;
      mask_q    <= MASK_RESET;
      thr_q     <= THR_RESET;
      en_q      <= 1'b0;
    end else if (wr_ok) begin
      persist_q <= persist_d;
      mask_q    <= mask_d;
      thr_q     <= thr_d;
      en_q      <= en_d;
    end
  end

  assign persist = persist_q;
  assign mask    = mask_q;
  assign thr     = thr_q;
  assign fn_en   = en_q;

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable({persist_q, mask_q, thr_q, en_q})); // R9
endmodule

// File: rtl/orient_persist.sv
module orient_persist
  import orient_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [POS_W-1:0] cand,
  input  logic [POS_W-1:0] cur,
  input  logic [CNT_W-1:0] limit,
  output logic             accept
);
  logic [POS_W-1:0] track_q, track_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] run_len;
  logic             differs;
  logic             hit;

  // run_len = consecutive earlier samples that showed this same candidate
  always_comb begin
    differs = (cand != cur);
    if (cand == track_q && cnt_q != {CNT_W{1'b1}}) begin
      run_len = cnt_q + 1'b1;
    end else if (cand == track_q) begin
      run_len = cnt_q;
    end else begin
      run_len = '0;
    end
    hit     = differs && (run_len >= limit);
    accept  = step && hit;
    track_d = track_q;
    cnt_d   = cnt_q;
    if (step) begin
      if (!differs || hit) begin
        track_d = cand;
        cnt_d   = '0;
      end else begin
        track_d = cand;
        cnt_d   = run_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      track_q <= POS_RESET;
      cnt_q   <= '0;
    end else if (step) begin
      track_q <= track_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_SAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cand == cur) |=> (cnt_q == '0)); // R4
  AST_NEW_CAND_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cand != cur && cand != track_q && !accept) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/orient_state.sv
module orient_state
  import orient_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [POS_W-1:0] new_pos,
  input  logic [POS_W-1:0] mask,
  input  logic             rel,
  output logic [POS_W-1:0] cur,
  output logic [POS_W-1:0] prev,
  output logic             flag
);
  logic [POS_W-1:0] cur_q, prev_q;
  logic             flag_q, flag_d;
  logic             raise;

  assign raise = accept && |(new_pos & mask);

  always_comb begin
    flag_d = flag_q;
    if (raise) begin
      flag_d = 1'b1;
    end else if (rel) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= POS_RESET;
      prev_q <= POS_RESET;
    end else if (accept) begin
      cur_q  <= new_pos;
      prev_q <= cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
  assign flag = flag_q;

  AST_CUR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cur_q) == 1); // R1
  AST_PREV_TAKES_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (prev_q == $past(cur_q))); // R5
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (new_pos & mask) == '0 && !flag_q) |=> !flag_q); // R6
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !rel) |=> flag_q); // R7
endmodule

// File: rtl/orient_debounce.sv
module orient_debounce
  import orient_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     cfg_wr,
  input  logic [1:0]               cfg_addr,
  input  logic [CFG_DW-1:0]        cfg_wdata,
  input  logic                     smp_vld,
  input  logic signed [DATA_W-1:0] acc_x,
  input  logic signed [DATA_W-1:0] acc_y,
  input  logic signed [DATA_W-1:0] acc_z,
  input  logic                     int_rel,
  output logic [7:0]               pos_cur,
  output logic [7:0]               pos_prev,
  output logic                     pos_chg
);
  logic [CNT_W-1:0]  persist;
  logic [POS_W-1:0]  mask;
  logic [CFG_DW-1:0] thr;
  logic              fn_en;
  logic [POS_W-1:0]  cur, prev, cand;
  logic              step, accept, flag;

  orient_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .run(run), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .persist(persist), .mask(mask), .thr(thr), .fn_en(fn_en)
  );

  orient_classify #(.DATA_W(DATA_W)) u_cls (
    .ax(acc_x), .ay(acc_y), .az(acc_z), .thr(thr), .cur(cur), .cand(cand)
  );

  assign step = smp_vld & run & fn_en;

  orient_persist u_per (
    .clk(clk), .rst_n(rst_n), .step(step), .cand(cand), .cur(cur),
    .limit(persist), .accept(accept)
  );

  orient_state u_st (
    .clk(clk), .rst_n(rst_n), .accept(accept), .new_pos(cand), .mask(mask),
    .rel(int_rel), .cur(cur), .prev(prev), .flag(flag)
  );

  assign pos_cur  = {2'b00, cur};
  assign pos_prev = {2'b00, prev};
  assign pos_chg  = flag;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_vld && run && fn_en) |=> $stable(pos_cur)); // R8
  AST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_cur[7:6] == 2'b00) && (pos_prev[7:6] == 2'b00)); // R1
endmodule

// File: tb/orient_debounce_tb.sv
module orient_debounce_tb;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic run, cfg_wr, smp_vld, int_rel;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic signed [DATA_W-1:0] acc_x, acc_y, acc_z;
  logic [7:0] pos_cur, pos_prev;
  logic pos_chg;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model state
  logic [7:0] m_timer = 8'd0;
  logic [5:0] m_mask  = 6'h3F;
  logic [7:0] m_thr   = 8'h20;
  logic       m_en    = 1'b0;
  logic [5:0] m_cur   = 6'h20;
  logic [5:0] m_prev  = 6'h20;
  logic       m_flag  = 1'b0;
  logic [5:0] m_track = 6'h20;
  int         m_cnt   = 0;

  always #(CLK_P/2) clk = ~clk;

  orient_debounce #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smp_vld(smp_vld), .acc_x(acc_x), .acc_y(acc_y),
    .acc_z(acc_z), .int_rel(int_rel), .pos_cur(pos_cur), .pos_prev(pos_prev),
    .pos_chg(pos_chg)
  );

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // R2: largest magnitude wins, ties X>Y>Z, strict threshold*16
  function automatic logic [5:0] classify(input int x, input int y, input int z,
                                          input logic [7:0] thr, input logic [5:0] cur);
    int mx, my, mz, m, ax;
    bit ng;
    mx = iabs(x); my = iabs(y); mz = iabs(z);
    if (mx >= my && mx >= mz) begin m = mx; ax = 0; ng = (x < 0); end
    else if (my >= mz)         begin m = my; ax = 1; ng = (y < 0); end
    else                       begin m = mz; ax = 2; ng = (z < 0); end
    if (m <= int'(thr) * 16) return cur;
    return 6'b1 << (2 * (2 - ax) + (ng ? 1 : 0));
  endfunction

  task automatic model_edge();
    logic [5:0] c;
    int n;
    bit raise = 0;
    if (cfg_wr && !run) begin
      case (cfg_addr)
        2'd0: m_timer = cfg_wdata;
        2'd1: m_mask  = cfg_wdata[5:0];
        2'd2: m_thr   = cfg_wdata;
        default: m_en = cfg_wdata[0];
      endcase
    end
    if (smp_vld && run && m_en) begin
      c = classify(int'(acc_x), int'(acc_y), int'(acc_z), m_thr, m_cur);
      if (c == m_cur) begin
        m_track = m_cur; m_cnt = 0;
      end else begin
        n = (c == m_track) ? m_cnt + 1 : 0;
        if (n >= int'(m_timer)) begin
          m_prev = m_cur; m_cur = c; m_track = c; m_cnt = 0;
          raise = |(c & m_mask);
        end else begin
          m_track = c; m_cnt = n;
        end
      end
    end
    if (raise) m_flag = 1'b1;
    else if (int_rel) m_flag = 1'b0;
  endtask

  task automatic compare(input string tag);
    logic [16:0] act, exp;
    act = {pos_cur, pos_prev, pos_chg};
    exp = {2'b00, m_cur, 2'b00, m_prev, m_flag};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: cur/prev/chg actual %h/%h/%b expected %h/%h/%b", tag,
               pos_cur, pos_prev, pos_chg, {2'b00, m_cur}, {2'b00, m_prev}, m_flag);
    end
  endtask

  // inputs are set by the caller away from the edge; tick advances one edge
  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    #(CLK_P/4);
    compare(tag);
    cfg_wr = 0; smp_vld = 0; int_rel = 0;
  endtask

  task automatic cfg(input logic [1:0] a, input logic [7:0] d, input string tag);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    tick(tag);
  endtask

  task automatic smp(input int x, input int y, input int z, input logic rel, input string tag);
    smp_vld = 1; acc_x = DATA_W'(x); acc_y = DATA_W'(y); acc_z = DATA_W'(z);
    int_rel = rel;
    tick(tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(2024);
    rst_n = 0; run = 0; cfg_wr = 0; smp_vld = 0; int_rel = 0;
    cfg_addr = 0; cfg_wdata = 0; acc_x = 0; acc_y = 0; acc_z = 0;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    compare("R1 reset");
    @(negedge clk); rst_n = 1;
    #1;

    // R8: enable resets to 0, samples ignored
    run = 1;
    smp(1500, 0, 0, 0, "R8 disabled");
    run = 0;
    smp(1500, 0, 0, 0, "R8 not running");
    cfg(2'd3, 8'h01, "R9 enable write");
    run = 1;
    // R3 timer 0 (reset value): first sample accepted; R5 R6
    smp(1500, 0, 0, 0, "R3 T0 accept");
    smp(0, 0, 0, 0, "R2 below threshold holds");
    int_rel = 1; tick("R7 release");
    // R9 locked write ignored: timer stays 0
    cfg(2'd0, 8'h03, "R9 locked write");
    smp(0, -1000, 0, 0, "R9 timer unchanged");
    // R3 T=2
    run = 0; cfg(2'd0, 8'h02, "R9 timer write"); run = 1;
    int_rel = 1; tick("R7 release");
    smp(0, 0, -1000, 0, "R3 first");
    smp(0, 0, -1000, 0, "R3 second");
    smp(0, 0, -1000, 0, "R3 third accepts");
    // R4 restart
    smp(0, 1000, 0, 0, "R4 cand A");
    smp(0, 1000, 0, 0, "R4 cand A2");
    smp(0, 0, 1000, 0, "R4 cand B restarts");
    smp(0, 1000, 0, 0, "R4 cand A restarts");
    smp(0, 0, -1000, 0, "R4 current clears");
    smp(0, 1000, 0, 0, "R4 again 1");
    smp(0, 1000, 0, 0, "R4 again 2");
    smp(0, 1000, 0, 0, "R4 again 3 accepts");
    // R2 ties and full scale
    run = 0; cfg(2'd0, 8'h00, "R9 timer 0"); run = 1;
    smp(700, -700, 700, 0, "R2 tie picks X");
    smp(-2048, 2047, 0, 0, "R2 full scale");
    smp(0, 512, 0, 0, "R2 at threshold holds");
    smp(0, 513, 0, 0, "R2 above threshold");
    // R6 masked entry
    int_rel = 1; tick("R7 release");
    run = 0; cfg(2'd1, 8'h01, "R6 mask Z+ only"); run = 1;
    smp(0, 0, -900, 0, "R6 masked no flag");
    smp(0, 0, 900, 0, "R6 enabled flag");
    // R7 set wins over release
    smp(900, 0, 0, 1, "R7 masked with release clears");
    smp(0, 0, 900, 1, "R7 set over release");
    // R8 enable off
    run = 0; cfg(2'd3, 8'h00, "R8 disable"); run = 1;
    smp(0, -900, 0, 0, "R8 ignored when disabled");
    run = 0; cfg(2'd3, 8'h01, "R8 enable"); run = 1;

    // constrained random phases
    for (int ph = 0; ph < 40; ph++) begin
      run = 0;
      cfg(2'd0, 8'($urandom % 4), "R9 rnd timer");
      cfg(2'd1, 8'($urandom % 64), "R9 rnd mask");
      cfg(2'd2, 8'(16 << ($urandom % 3)), "R9 rnd thr");
      run = 1;
      for (int k = 0; k < 12; k++) begin
        int v[3];
        int hold;
        for (int a = 0; a < 3; a++) v[a] = int'($urandom % 400) - 200;
        v[$urandom % 3] = (($urandom % 2) != 0 ? 1 : -1) * int'(200 + $urandom % 1849);
        hold = 1 + int'($urandom % 5);
        for (int h = 0; h < hold; h++) begin
          if (($urandom % 4) == 0) begin
            int_rel = (($urandom % 8) == 0);
            tick("R8 idle cycle");
          end else begin
            smp(v[0], v[1], v[2], (($urandom % 10) == 0), "R3 R4 R6 random");
          end
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule